// File: doc/BRIEF.md
# Interrupt Entry and Register Banking Unit

This unit is the part of a processor core that takes normal and fast interrupts. Every cycle it weighs the two request lines against the two disable bits in its status word. When a request is accepted, the unit saves the return link and the old status word into registers owned by the new mode. It then sets the mode field and the disable bits, and redirects the program counter to the vector for that class. A return strobe, which carries the link value, sends the program counter back and restores the status word that was saved for the current mode.

The unit also keeps the mode-dependent copies of the upper general registers (R8 to R12), the stack pointer and the link register. One read/write port reaches them, and the current mode steers each access to the right copy. Fast mode has its own copy of all seven. Normal-interrupt mode has its own stack pointer and link register only. Every other mode uses the common system copy. A status write port lets surrounding logic set or clear the disable bits and change the mode. Instruction decode, the ALU and memory are outside this unit.

Top module: `exc_entry_unit`

## Requirements
- R1: After synchronous reset, status is 0xD3: I (bit 7) = 1, F (bit 6) = 1, mode (bits 4:0) = 0x13. pc_load is 0 and every banked register reads 0.
- R2: In a cycle with no return and no status write, irq_req = 1 with I clear and no enabled fast request causes the following on the next cycle: pc_out = 0x18, pc_load = 1, mode = 0x12 and I set. F and all other status bits keep their value.
- R3: In a cycle with no return and no status write, fiq_req = 1 with F clear causes the following on the next cycle: pc_out = 0x1C, pc_load = 1, mode = 0x11, and both I and F set.
- R4: On either entry, the old status word is kept as the saved status of the mode entered, and ret_addr + 4 is written into that mode's link register (bank index 6).
- R5: When both requests are enabled in the same cycle, only the fast entry is taken. A normal request that is still held is taken later, once its disable bit is clear. A fast request can preempt the normal-interrupt mode, because that mode leaves F clear.
- R6: A normal request is ignored while I = 1 and a fast request is ignored while F = 1. pc_load stays 0 and the status word does not change.
- R7: ret_valid = 1 causes pc_out = ret_lr - 4 with pc_load = 1 on the next cycle. In mode 0x11 or 0x12 the status word is restored from that mode's saved status. In any other mode it is left unchanged. A return wins over a status write and over any entry in the same cycle.
- R8: bank_sel values 0 to 4 select R8 to R12, 5 selects SP, 6 selects LR, and 7 reads 0 and ignores writes. In mode 0x11 all of indices 0 to 6 use the fast copy. In mode 0x12 only indices 5 and 6 use the normal-interrupt copy. All other accesses use the system copy. A write takes effect only in a cycle with no entry, return or status write.
- R9: st_we = 1 with no return loads st_wdata into the status word on the next cycle and blocks any entry in that cycle.
- R10: pc_load is a one-cycle pulse that follows only an entry or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Normal interrupt request level |
| fiq_req | input | 1 | Fast interrupt request level |
| ret_addr | input | DW | Return address of the interrupted flow |
| ret_valid | input | 1 | Return-from-handler strobe |
| ret_lr | input | DW | Link value carried by the return strobe |
| st_we | input | 1 | Status word write enable |
| st_wdata | input | DW | Status word write data |
| bank_sel | input | 3 | Banked register index |
| bank_we | input | 1 | Banked register write enable |
| bank_wdata | input | DW | Banked register write data |
| bank_rdata | output | DW | Banked register read data for the current mode |
| status_out | output | DW | Current status word |
| pc_out | output | DW | Redirect target |
| pc_load | output | 1 | Redirect strobe |

## Verification
The unit is driven through several request patterns. A normal request alone, with I first set and then clear, shows masking apart from acceptance. A fast request alone shows which bits each class disables. Both requests raised together show the priority order and that the losing request stays pending. A fast request raised inside normal-interrupt mode shows nesting, and the two returns that follow must unwind the saved status words in the right order. Register traffic in system, fast and normal-interrupt modes shows which indices each mode swaps. Returns made in a mode without a saved status, and returns that collide with a request, show the precedence between return and entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam logic [4:0] MODE_USR = 5'h10;
    localparam logic [4:0] MODE_FIQ = 5'h11;
    localparam logic [4:0] MODE_IRQ = 5'h12;
    localparam logic [4:0] MODE_SVC = 5'h13;

    localparam int BIT_I = 7;
    localparam int BIT_F = 6;

    localparam logic [31:0] VEC_IRQ    = 32'h0000_0018;
    localparam logic [31:0] VEC_FIQ    = 32'h0000_001C;
    localparam logic [31:0] RESET_STAT = 32'h0000_00D3;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_IRQ,
        EV_FIQ,
        EV_RET,
        EV_STW
    } exc_ev_e;

    typedef enum logic [1:0] {
        BK_SYS,
        BK_FIQ,
        BK_IRQ
    } bank_e;

    function automatic bank_e bank_for(logic [4:0] mode, logic is_sp_lr);
        if (mode == MODE_FIQ)                 return BK_FIQ;
        else if (mode == MODE_IRQ && is_sp_lr) return BK_IRQ;
        else                                   return BK_SYS;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic    irq_req,
    input  logic    fiq_req,
    input  logic    ret_valid,
    input  logic    st_we,
    input  logic    i_bit,
    input  logic    f_bit,
    output exc_ev_e ev
);
    always_comb begin
        if (ret_valid)                ev = EV_RET;
        else if (st_we)               ev = EV_STW;
        else if (fiq_req && !f_bit)   ev = EV_FIQ;
        else if (irq_req && !i_bit)   ev = EV_IRQ;
        else                          ev = EV_NONE;
    end
endmodule

// File: rtl/exc_psr.sv
module exc_psr
    import exc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  exc_ev_e       ev,
    input  logic [DW-1:0] ret_lr,
    input  logic [DW-1:0] st_wdata,
    output logic [DW-1:0] status,
    output logic [DW-1:0] pc_out,
    output logic          pc_load
);
    logic [DW-1:0] saved_fiq;
    logic [DW-1:0] saved_irq;
    logic [4:0]    mode;

    assign mode = status[4:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= DW'(RESET_STAT);
            saved_fiq <= '0;
            saved_irq <= '0;
            pc_out    <= '0;
            pc_load   <= 1'b0;
        end else begin
            pc_load <= (ev == EV_FIQ) || (ev == EV_IRQ) || (ev == EV_RET);
            unique case (ev)
                EV_FIQ: begin
                    saved_fiq    <= status;
                    status[BIT_I] <= 1'b1;
                    status[BIT_F] <= 1'b1;
                    status[4:0]  <= MODE_FIQ;
                    pc_out       <= DW'(VEC_FIQ);
                end
                EV_IRQ: begin
                    saved_irq    <= status;
                    status[BIT_I] <= 1'b1;
                    status[4:0]  <= MODE_IRQ;
                    pc_out       <= DW'(VEC_IRQ);
                end
                EV_RET: begin
                    pc_out <= ret_lr - DW'(4);
                    if (mode == MODE_FIQ)      status <= saved_fiq;
                    else if (mode == MODE_IRQ) status <= saved_irq;
                end
                EV_STW: status <= st_wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
    import exc_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  exc_ev_e                  ev,
    input  logic [4:0]               mode,
    input  logic [$clog2(NREG+1)-1:0] sel,
    input  logic                     we,
    input  logic [DW-1:0]            wdata,
    input  logic [DW-1:0]            link_val,
    output logic [DW-1:0]            rdata
);
    localparam int SELW   = $clog2(NREG + 1);
    localparam int SP_IDX = NREG - 2;
    localparam int LR_IDX = NREG - 1;

    logic [DW-1:0] sys_q [NREG];
    logic [DW-1:0] fiq_q [NREG];
    logic [DW-1:0] irq_q [2];

    logic  in_range;
    logic  is_sp_lr;
    bank_e bk;
    logic  wr_ok;

    assign in_range = (sel < SELW'(NREG));
    assign is_sp_lr = (sel >= SELW'(SP_IDX)) && in_range;
    assign bk       = bank_for(mode, is_sp_lr);
    assign wr_ok    = we && in_range && (ev == EV_NONE);

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                sys_q[g] <= '0;
            end else if (wr_ok && bk == BK_SYS && sel == SELW'(g)) begin
                sys_q[g] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                fiq_q[g] <= '0;
            end else if (ev == EV_FIQ && g == LR_IDX) begin
                fiq_q[g] <= link_val;
            end else if (wr_ok && bk == BK_FIQ && sel == SELW'(g)) begin
                fiq_q[g] <= wdata;
            end
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_irq
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_q[h] <= '0;
            end else if (ev == EV_IRQ && h == 1) begin
                irq_q[h] <= link_val;
            end else if (wr_ok && bk == BK_IRQ && sel == SELW'(SP_IDX + h)) begin
                irq_q[h] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) begin
            unique case (bk)
                BK_FIQ:  rdata = fiq_q[sel];
                BK_IRQ:  rdata = irq_q[sel == SELW'(LR_IDX)];
                default: rdata = sys_q[sel];
            endcase
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      irq_req,
    input  logic                      fiq_req,
    input  logic [DW-1:0]             ret_addr,
    input  logic                      ret_valid,
    input  logic [DW-1:0]             ret_lr,
    input  logic                      st_we,
    input  logic [DW-1:0]             st_wdata,
    input  logic [$clog2(NREG+1)-1:0] bank_sel,
    input  logic                      bank_we,
    input  logic [DW-1:0]             bank_wdata,
    output logic [DW-1:0]             bank_rdata,
    output logic [DW-1:0]             status_out,
    output logic [DW-1:0]             pc_out,
    output logic                      pc_load
);
    exc_ev_e       ev;
    logic [DW-1:0] link_val;

    assign link_val = ret_addr + DW'(4);

    exc_arbiter u_arb (
        .irq_req   (irq_req),
        .fiq_req   (fiq_req),
        .ret_valid (ret_valid),
        .st_we     (st_we),
        .i_bit     (status_out[BIT_I]),
        .f_bit     (status_out[BIT_F]),
        .ev        (ev)
    );

    exc_psr #(.DW(DW)) u_psr (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .ret_lr   (ret_lr),
        .st_wdata (st_wdata),
        .status   (status_out),
        .pc_out   (pc_out),
        .pc_load  (pc_load)
    );

    exc_bank_file #(.DW(DW), .NREG(NREG)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .mode     (status_out[4:0]),
        .sel      (bank_sel),
        .we       (bank_we),
        .wdata    (bank_wdata),
        .link_val (link_val),
        .rdata    (bank_rdata)
    );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          irq_req,
    input logic          fiq_req,
    input logic          ret_valid,
    input logic [DW-1:0] ret_lr,
    input logic          st_we,
    input logic [DW-1:0] status_out,
    input logic [DW-1:0] pc_out,
    input logic          pc_load
);
    logic quiet;
    logic fiq_go;
    logic irq_go;

    assign quiet  = !ret_valid && !st_we;
    assign fiq_go = quiet && fiq_req && !status_out[BIT_F];
    assign irq_go = quiet && irq_req && !status_out[BIT_I] && !fiq_go;

    a_r2_irq_entry: assert property (@(posedge clk) disable iff (rst)
        irq_go |=> (pc_load && pc_out == DW'(VEC_IRQ) &&
                    status_out[4:0] == MODE_IRQ && status_out[BIT_I]));

    a_r2_irq_keeps_f: assert property (@(posedge clk) disable iff (rst)
        irq_go |=> (status_out[BIT_F] == $past(status_out[BIT_F])));

    a_r3_fiq_entry: assert property (@(posedge clk) disable iff (rst)
        fiq_go |=> (pc_load && pc_out == DW'(VEC_FIQ) &&
                    status_out[4:0] == MODE_FIQ &&
                    status_out[BIT_I] && status_out[BIT_F]));

    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (quiet && !fiq_go && !irq_go) |=> (!pc_load && $stable(status_out)));

    a_r7_return_target: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> (pc_load && pc_out == $past(ret_lr) - DW'(4)));

    a_r9_status_write: assert property (@(posedge clk) disable iff (rst)
        (st_we && !ret_valid) |=> !pc_load);
endmodule

bind exc_entry_unit exc_entry_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .fiq_req    (fiq_req),
    .ret_valid  (ret_valid),
    .ret_lr     (ret_lr),
    .st_we      (st_we),
    .status_out (status_out),
    .pc_out     (pc_out),
    .pc_load    (pc_load)
);

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          irq_req, fiq_req, ret_valid, st_we, bank_we;
    logic [DW-1:0] ret_addr, ret_lr, st_wdata, bank_wdata;
    logic [2:0]    bank_sel;
    logic [DW-1:0] bank_rdata, status_out, pc_out;
    logic          pc_load;

    always #5 clk = ~clk;

    exc_entry_unit uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .fiq_req(fiq_req),
        .ret_addr(ret_addr), .ret_valid(ret_valid), .ret_lr(ret_lr),
        .st_we(st_we), .st_wdata(st_wdata), .bank_sel(bank_sel),
        .bank_we(bank_we), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
        .status_out(status_out), .pc_out(pc_out), .pc_load(pc_load)
    );

    // Behavioural reference: bank 0 system, 1 fast, 2 normal
    logic [31:0] m_status, m_pc, m_sav_f, m_sav_i;
    logic        m_load;
    logic [31:0] m_reg [3][7];
    int          n_checks = 0;
    int          n_fail   = 0;
    string       cur_req  = "R1";

    function automatic int m_bank(logic [31:0] st, int sel);
        if (st[4:0] == 5'h11) return 1;
        if (st[4:0] == 5'h12 && sel >= 5) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_status = 32'hD3; m_pc = 0; m_load = 0; m_sav_f = 0; m_sav_i = 0;
            for (int b = 0; b < 3; b++)
                for (int r = 0; r < 7; r++) m_reg[b][r] = 0;
        end else if (ret_valid) begin
            m_load = 1; m_pc = ret_lr - 4;
            if (m_status[4:0] == 5'h11) m_status = m_sav_f;
            else if (m_status[4:0] == 5'h12) m_status = m_sav_i;
        end else if (st_we) begin
            m_load = 0; m_status = st_wdata;
        end else if (fiq_req && !m_status[6]) begin
            m_load = 1; m_pc = 32'h1C; m_sav_f = m_status;
            m_reg[1][6] = ret_addr + 4;
            m_status = (m_status & ~32'h1F) | 32'hC0 | 32'h11;
        end else if (irq_req && !m_status[7]) begin
            m_load = 1; m_pc = 32'h18; m_sav_i = m_status;
            m_reg[2][6] = ret_addr + 4;
            m_status = (m_status & ~32'h1F) | 32'h80 | 32'h12;
        end else begin
            m_load = 0;
            if (bank_we && bank_sel < 7)
                m_reg[m_bank(m_status, int'(bank_sel))][bank_sel] = bank_wdata;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("status", status_out, m_status);
            chk("pc_load", {31'b0, pc_load}, {31'b0, m_load});
            if (m_load) chk("pc", pc_out, m_pc);
            chk("rdata", bank_rdata,
                (bank_sel < 7) ? m_reg[m_bank(m_status, int'(bank_sel))][bank_sel] : 32'h0);
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bwrite(int sel, logic [31:0] v);
        bank_sel = 3'(sel); bank_wdata = v; bank_we = 1; cyc(); bank_we = 0;
    endtask

    task automatic ret(logic [31:0] lr);
        ret_valid = 1; ret_lr = lr; cyc(); ret_valid = 0;
    endtask

    task automatic stw(logic [31:0] v);
        st_we = 1; st_wdata = v; cyc(); st_we = 0;
    endtask

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1; irq_req = 0; fiq_req = 0; ret_valid = 0; st_we = 0; bank_we = 0;
        ret_addr = 32'h1000; ret_lr = 0; st_wdata = 0; bank_sel = 0; bank_wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cur_req = "R1"; cyc(2);
        chk("R1 reset status", status_out, 32'hD3);
        for (int s = 0; s < 8; s++) begin bank_sel = 3'(s); cyc(); end

        cur_req = "R8";
        for (int s = 0; s < 8; s++) bwrite(s, 32'hA000 + s);
        for (int s = 0; s < 8; s++) begin bank_sel = 3'(s); cyc(); end

        cur_req = "R6"; irq_req = 1; fiq_req = 1; cyc(4);
        chk("R6 masked, no redirect", {31'b0, pc_load}, 32'h0);
        fiq_req = 0;

        cur_req = "R9"; stw(32'h53);
        cur_req = "R2"; cyc();
        chk("R2 irq mode", status_out, 32'h92 | 32'h40);
        irq_req = 0;
        cur_req = "R4"; bank_sel = 6; cyc();
        chk("R4 irq link", bank_rdata, 32'h1004);
        cur_req = "R8"; bwrite(5, 32'h5555); bank_sel = 0; cyc();
        bank_sel = 5; cyc();
        cur_req = "R7"; ret(32'h1004);
        chk("R7 restore", status_out, 32'h53);

        cur_req = "R5"; ret_addr = 32'h2000; stw(32'h13);
        irq_req = 1; fiq_req = 1; cyc();
        chk("R5 fiq wins", status_out, 32'hD1);
        fiq_req = 0; cyc(3);
        cur_req = "R8";
        for (int s = 0; s < 7; s++) begin bank_sel = 3'(s); cyc(); end
        bwrite(0, 32'hF0F0); bank_sel = 0; cyc();
        cur_req = "R5"; ret_addr = 32'h3000; ret(32'h2004);
        cyc();
        chk("R5 irq taken later", status_out, 32'h92);
        irq_req = 0;
        cur_req = "R5"; fiq_req = 1; cyc();
        chk("R5 fiq nests", status_out, 32'hD1);
        fiq_req = 0;
        cur_req = "R7"; ret(32'h3004);
        chk("R7 back to irq", status_out, 32'h92);
        ret(32'h3004);
        chk("R7 back to svc", status_out, 32'h13);

        cur_req = "R7"; stw(32'hD3); ret(32'h4444);
        chk("R7 svc return keeps status", status_out, 32'hD3);
        stw(32'h13); irq_req = 1; ret_valid = 1; ret_lr = 32'h808; cyc();
        ret_valid = 0; irq_req = 0;
        chk("R7 return beats entry", pc_out, 32'h804);
        cur_req = "R10"; cyc(2);
        chk("R10 pulse ended", {31'b0, pc_load}, 32'h0);
        cur_req = "R9"; stw(32'h10); irq_req = 1; st_we = 1; st_wdata = 32'h10; cyc();
        st_we = 0; irq_req = 0; cyc();
        cur_req = "R8"; bank_sel = 7; bwrite(7, 32'hDEAD); cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule